// File: doc/BRIEF.md
# DRAM Access and DMA Readout Sequencer

This block drives the strobes of one DRAM array that is split into a low byte bank and a high byte bank. Two masters share the array. The first is a host processor, which announces a cycle with an active-low address strobe. The second is a DMA readout engine, which is granted the bus after the processor acknowledges a hold. For each access the sequencer asserts the row strobe first. One tick later it switches the external multiplexer to column addresses. It then drops the column strobe of each targeted bank. The block also decides whether the access is a write.

For a processor access, the bank is picked from address bit 23, address bit 0 and the high-byte enable. The values are sampled when the cycle is launched. A DMA grant always runs a pair of reads back to back. Each read is longer than a processor access by a number of wait ticks. Both banks are strobed together on every DMA read. An address-bit-1 output separates the two words. A latch pulse goes to the first converter for word one and to the second converter for word two. After the pair, the sequencer parks with the engine disabled until the hold acknowledge is withdrawn.

The two request inputs are asynchronous and pass through a synchroniser chain. The alignment input is already synchronous and is used as it is. Time is counted in clock ticks.

Top module: `memseq_ctrl`

## Requirements
- R1: A falling edge of `as_n` launches one processor cycle. With the default two synchroniser stages, `ras_n` goes low on the fourth rising clock edge counted from the first edge that samples `as_n` low. Holding `as_n` low does not launch a further cycle.
- R2: In every cycle `ras_n` falls while `col_n` is high, and `col_n` falls exactly one tick after `ras_n`. The pending-launch flag is cleared when `col_n` falls. A new `as_n` fall that arrives during a cycle is kept and starts the next cycle as soon as the sequencer is idle.
- R3: In a processor cycle, `lcas_n` is driven low only when `addr_hi`=1 and `addr_b0`=0. `hcas_n` is driven low only when `addr_hi`=1 and `hbe_n`=0. When `addr_hi`=0, neither column strobe is asserted. The inputs are sampled when the cycle is launched.
- R4: `we_n` is shared by both banks. In a processor cycle it is low, for exactly the ticks in which `col_n` is low, only when `wr_req`=1 and at least one column strobe is enabled.
- R5: A processor cycle (CPU_COL_TICKS=2) holds `ras_n` low for 3 ticks. It holds `col_n` and the enabled column strobes low for 3 ticks, starting one tick after `ras_n` falls and ending one tick after `ras_n` rises. After that all strobes are high.
- R6: A DMA pair starts only while the sequencer is idle, the synchronised `hold_ack_n` is low and `align_n` is low. `dma_oe_n` goes low on that edge, which is one tick before the first row strobe. While `align_n` is high, no DMA pair starts.
- R7: During a DMA read, `lcas_n` and `hcas_n` fall and rise together, and `we_n` stays high.
- R8: Each DMA read (DMA_WAIT_TICKS=2) holds `ras_n` low for 3 ticks, with the release falling in the last wait tick. It holds `col_n` and both column strobes low for 4 ticks. It holds its latch strobe low for 3 ticks, so the latch rises while the column strobes are still low.
- R9: Every DMA grant performs exactly two reads. In the first read `dma_a1`=0 and `latch1_n` pulses. In the second read `dma_a1`=1 and `latch2_n` pulses. The two latches are never low at the same time.
- R10: After the second read, `dma_oe_n` returns high and all strobes stay high. No new pair starts until the synchronised `hold_ack_n` has been high again.
- R11: During and right after reset, every active-low output is high and `dma_a1` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Processor address strobe, active low, asynchronous |
| hold_ack_n | input | 1 | Processor hold acknowledge, active low, asynchronous |
| align_n | input | 1 | Cycle-alignment qualifier, active low, synchronous |
| addr_hi | input | 1 | Processor address bit 23 (DRAM select) |
| addr_b0 | input | 1 | Processor address bit 0 (low byte when 0) |
| hbe_n | input | 1 | High byte enable, active low |
| wr_req | input | 1 | 1 for a processor write, 0 for a read |
| ras_n | output | 1 | Row address strobe |
| col_n | output | 1 | Row/column select, low selects column address |
| lcas_n | output | 1 | Low bank column strobe |
| hcas_n | output | 1 | High bank column strobe |
| we_n | output | 1 | Shared write enable |
| dma_oe_n | output | 1 | Readout engine address enable |
| dma_a1 | output | 1 | Address bit 1 driven during DMA words |
| latch1_n | output | 1 | Data latch strobe for converter one |
| latch2_n | output | 1 | Data latch strobe for converter two |

## Verification
Processor cycles are run for all sixteen combinations of `addr_hi`, `addr_b0`, `hbe_n` and `wr_req`. This separates the low-bank, high-bank and no-bank decodes, and it shows whether a write without a target bank is suppressed. A second strobe fall placed inside a running cycle shows whether the launch flag is kept rather than lost. DMA grants are applied twice. In the first, alignment is already low when the hold arrives. In the second, the hold is already low when alignment arrives. Together these show that both qualifiers gate the start. The long hold after each pair shows that the park state does not restart the burst.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_C_ROW   = 4'd1,
      ST_C_COL   = 4'd2,
      ST_C_PRE   = 4'd3,
      ST_D_SETUP = 4'd4,
      ST_D_ROW   = 4'd5,
      ST_D_COL   = 4'd6,
      ST_D_WAIT  = 4'd7,
      ST_D_END   = 4'd8,
      ST_D_PARK  = 4'd9
   } seq_state_t;

   typedef struct packed {
      logic lo_en;
      logic hi_en;
      logic wr;
   } cpu_req_t;

endpackage

// File: rtl/memseq_sync.sv
module memseq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/memseq_bank_dec.sv
module memseq_bank_dec
   import memseq_pkg::*;
(
   input  logic     addr_hi,
   input  logic     addr_b0,
   input  logic     hbe_n,
   input  logic     wr_req,
   output cpu_req_t req
);
   always_comb begin
      req.lo_en = addr_hi & ~addr_b0;
      req.hi_en = addr_hi & ~hbe_n;
      req.wr    = wr_req;
   end
endmodule

// File: rtl/memseq_fsm.sv
module memseq_fsm
   import memseq_pkg::*;
#(
   parameter int CPU_COL_TICKS  = 2,
   parameter int DMA_WAIT_TICKS = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     as_s,
   input  logic     hold_s,
   input  logic     align_n,
   input  cpu_req_t req_in,
   output logic     ras_n,
   output logic     col_n,
   output logic     lcas_n,
   output logic     hcas_n,
   output logic     we_n,
   output logic     dma_oe_n,
   output logic     dma_a1,
   output logic     latch1_n,
   output logic     latch2_n
);
   localparam int MAX_T = (CPU_COL_TICKS > DMA_WAIT_TICKS) ? CPU_COL_TICKS : DMA_WAIT_TICKS;
   localparam int CW    = (MAX_T < 2) ? 1 : $clog2(MAX_T);
   localparam logic [CW-1:0] CPU_LAST = CW'(CPU_COL_TICKS - 1);
   localparam logic [CW-1:0] DMA_LAST = CW'(DMA_WAIT_TICKS - 1);

   seq_state_t      state, state_nx;
   logic [CW-1:0]   cnt;
   logic            as_d;
   logic            go;
   logic            word;
   cpu_req_t        cap;
   logic            as_fall;

   assign as_fall = ~as_s & as_d;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: begin
            if (go)                      state_nx = ST_C_ROW;
            else if (!hold_s && !align_n) state_nx = ST_D_SETUP;
         end
         ST_C_ROW:   state_nx = ST_C_COL;
         ST_C_COL:   if (cnt == CPU_LAST) state_nx = ST_C_PRE;
         ST_C_PRE:   state_nx = ST_IDLE;
         ST_D_SETUP: state_nx = ST_D_ROW;
         ST_D_ROW:   state_nx = ST_D_COL;
         ST_D_COL:   state_nx = ST_D_WAIT;
         ST_D_WAIT:  if (cnt == DMA_LAST) state_nx = ST_D_END;
         ST_D_END:   state_nx = word ? ST_D_PARK : ST_D_ROW;
         ST_D_PARK:  if (hold_s) state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         as_d  <= 1'b1;
         go    <= 1'b0;
         word  <= 1'b0;
         cap   <= '0;
      end else begin
         state <= state_nx;
         as_d  <= as_s;
         // Launch flag: a new fall wins over the clear at column time.
         if (as_fall)                go <= 1'b1;
         else if (state == ST_C_ROW) go <= 1'b0;
         if (state != state_nx) cnt <= '0;
         else                   cnt <= cnt + 1'b1;
         if (state == ST_IDLE && go) cap <= req_in;
         if (state == ST_D_SETUP)    word <= 1'b0;
         else if (state == ST_D_END) word <= ~word;
      end
   end

   logic row_on, col_on, cpu_cas, dma_cas, latch_on, dma_busy;

   always_comb begin
      row_on   = (state == ST_C_ROW) || (state == ST_C_COL) ||
                 (state == ST_D_ROW) || (state == ST_D_COL) ||
                 ((state == ST_D_WAIT) && (cnt != DMA_LAST));
      cpu_cas  = (state == ST_C_COL) || (state == ST_C_PRE);
      dma_cas  = (state == ST_D_COL) || (state == ST_D_WAIT) || (state == ST_D_END);
      col_on   = cpu_cas || dma_cas;
      latch_on = (state == ST_D_COL) || (state == ST_D_WAIT);
      dma_busy = (state == ST_D_SETUP) || (state == ST_D_ROW) || col_on && !cpu_cas;
   end

   assign ras_n    = ~row_on;
   assign col_n    = ~col_on;
   assign lcas_n   = ~((cpu_cas && cap.lo_en) || dma_cas);
   assign hcas_n   = ~((cpu_cas && cap.hi_en) || dma_cas);
   assign we_n     = ~(cpu_cas && cap.wr && (cap.lo_en || cap.hi_en));
   assign dma_oe_n = ~dma_busy;
   assign dma_a1   = word;
   assign latch1_n = ~(latch_on && !word);
   assign latch2_n = ~(latch_on && word);
endmodule

// File: rtl/memseq_ctrl.sv
module memseq_ctrl
   import memseq_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int CPU_COL_TICKS  = 2,
   parameter int DMA_WAIT_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   input  logic hold_ack_n,
   input  logic align_n,
   input  logic addr_hi,
   input  logic addr_b0,
   input  logic hbe_n,
   input  logic wr_req,
   output logic ras_n,
   output logic col_n,
   output logic lcas_n,
   output logic hcas_n,
   output logic we_n,
   output logic dma_oe_n,
   output logic dma_a1,
   output logic latch1_n,
   output logic latch2_n
);
   initial begin : param_check
      assert (SYNC_STAGES >= 2)    else $fatal(1, "SYNC_STAGES below 2");
      assert (CPU_COL_TICKS >= 1)  else $fatal(1, "CPU_COL_TICKS below 1");
      assert (DMA_WAIT_TICKS >= 1) else $fatal(1, "DMA_WAIT_TICKS below 1");
   end

   logic     as_s, hold_s;
   cpu_req_t req;

   memseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_as (
      .clk(clk), .rst_n(rst_n), .d_async(as_n), .q_sync(as_s));

   memseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_hold (
      .clk(clk), .rst_n(rst_n), .d_async(hold_ack_n), .q_sync(hold_s));

   memseq_bank_dec u_dec (
      .addr_hi(addr_hi), .addr_b0(addr_b0), .hbe_n(hbe_n),
      .wr_req(wr_req), .req(req));

   memseq_fsm #(.CPU_COL_TICKS(CPU_COL_TICKS), .DMA_WAIT_TICKS(DMA_WAIT_TICKS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .as_s(as_s), .hold_s(hold_s),
      .align_n(align_n), .req_in(req),
      .ras_n(ras_n), .col_n(col_n), .lcas_n(lcas_n), .hcas_n(hcas_n),
      .we_n(we_n), .dma_oe_n(dma_oe_n), .dma_a1(dma_a1),
      .latch1_n(latch1_n), .latch2_n(latch2_n));
endmodule

// File: rtl/memseq_ctrl_chk.sv
module memseq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic col_n,
   input logic lcas_n,
   input logic hcas_n,
   input logic we_n,
   input logic dma_oe_n,
   input logic dma_a1,
   input logic latch1_n,
   input logic latch2_n
);
   assert_ras_before_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> col_n);
   assert_col_under_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_n) |-> !ras_n);
   assert_cas_in_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lcas_n || !hcas_n) |-> !col_n);
   assert_we_with_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!lcas_n || !hcas_n));
   assert_dma_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_oe_n |-> we_n);
   assert_dma_cas_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_oe_n |-> (lcas_n == hcas_n));
   assert_latch_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~latch1_n, ~latch2_n}));
   assert_latch_in_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch1_n || !latch2_n) |-> !dma_oe_n);
   assert_a1_in_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_a1 |-> !dma_oe_n);
   assert_latch_rise_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(latch1_n) || $rose(latch2_n)) |-> (!lcas_n && !hcas_n));
endmodule

bind memseq_ctrl memseq_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .col_n(col_n),
   .lcas_n(lcas_n), .hcas_n(hcas_n), .we_n(we_n), .dma_oe_n(dma_oe_n),
   .dma_a1(dma_a1), .latch1_n(latch1_n), .latch2_n(latch2_n));

// File: tb/memseq_ctrl_test.sv
module memseq_ctrl_test;
   localparam int CLK_PERIOD = 50;
   localparam int LAUNCH     = 4;   // two sync stages + flag + state
   localparam int CCOL       = 2;
   localparam int DWAIT      = 2;
   localparam int WLEN       = 3 + DWAIT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic as_n = 1'b1, hold_ack_n = 1'b1, align_n = 1'b1;
   logic addr_hi = 1'b0, addr_b0 = 1'b0, hbe_n = 1'b1, wr_req = 1'b0;
   logic ras_n, col_n, lcas_n, hcas_n, we_n, dma_oe_n, dma_a1, latch1_n, latch2_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   memseq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .hold_ack_n(hold_ack_n),
      .align_n(align_n), .addr_hi(addr_hi), .addr_b0(addr_b0), .hbe_n(hbe_n),
      .wr_req(wr_req), .ras_n(ras_n), .col_n(col_n), .lcas_n(lcas_n),
      .hcas_n(hcas_n), .we_n(we_n), .dma_oe_n(dma_oe_n), .dma_a1(dma_a1),
      .latch1_n(latch1_n), .latch2_n(latch2_n));

   task automatic chk(input string req, input string what, input int k,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s tick %0d actual=%b expected=%b", req, what, k, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_chk(input string req, input int k);
      chk(req, "ras_n", k, ras_n, 1'b1);
      chk(req, "col_n", k, col_n, 1'b1);
      chk(req, "lcas_n", k, lcas_n, 1'b1);
      chk(req, "hcas_n", k, hcas_n, 1'b1);
      chk(req, "we_n", k, we_n, 1'b1);
      chk(req, "dma_oe_n", k, dma_oe_n, 1'b1);
      chk(req, "dma_a1", k, dma_a1, 1'b0);
      chk(req, "latch1_n", k, latch1_n, 1'b1);
      chk(req, "latch2_n", k, latch2_n, 1'b1);
   endtask

   // Processor cycle expectation for tick k after launch drive at d.
   task automatic cpu_expect(input int k, input int d, input logic lo, input logic hi,
                             input logic wr);
      logic row, col;
      row = (k >= d + LAUNCH) && (k <= d + LAUNCH + CCOL);
      col = (k >= d + LAUNCH + 1) && (k <= d + LAUNCH + CCOL + 1);
      chk("R1 R5", "ras_n", k, ras_n, ~row);
      chk("R2 R5", "col_n", k, col_n, ~col);
      chk("R3", "lcas_n", k, lcas_n, ~(col & lo));
      chk("R3", "hcas_n", k, hcas_n, ~(col & hi));
      chk("R4", "we_n", k, we_n, ~(col & wr & (lo | hi)));
      chk("R11", "dma_oe_n", k, dma_oe_n, 1'b1);
   endtask

   task automatic cpu_run(input logic h, input logic b0, input logic be, input logic wr);
      logic lo, hi;
      lo = h & ~b0;
      hi = h & ~be;
      addr_hi = h; addr_b0 = b0; hbe_n = be; wr_req = wr;
      as_n = 1'b0;
      for (int k = 1; k <= 12; k++) begin
         tick();
         cpu_expect(k, 0, lo, hi, wr);
      end
      as_n = 1'b1;
      repeat (4) tick();
   endtask

   // DMA pair expectation; s is the tick dma_oe_n first goes low.
   task automatic dma_trace(input int s, input int n);
      for (int k = 1; k <= n; k++) begin
         logic oe, row, col, l1, l2, a1;
         tick();
         oe = (k >= s) && (k <= s + 2 * WLEN);
         row = 1'b0; col = 1'b0; l1 = 1'b0; l2 = 1'b0; a1 = 1'b0;
         for (int w = 0; w < 2; w++) begin
            int off;
            off = k - (s + 1 + w * WLEN);
            if (off >= 0 && off <= DWAIT)     row = 1'b1;
            if (off >= 1 && off <= DWAIT + 2) col = 1'b1;
            if (off >= 1 && off <= DWAIT + 1) begin
               if (w == 0) l1 = 1'b1;
               else        l2 = 1'b1;
            end
            if (w == 1 && off >= 0 && off < WLEN) a1 = 1'b1;
         end
         chk("R6 R10", "dma_oe_n", k, dma_oe_n, ~oe);
         chk("R8", "ras_n", k, ras_n, ~row);
         chk("R8", "col_n", k, col_n, ~col);
         chk("R7", "lcas_n", k, lcas_n, ~col);
         chk("R7", "hcas_n", k, hcas_n, ~col);
         chk("R7", "we_n", k, we_n, 1'b1);
         chk("R9", "latch1_n", k, latch1_n, ~l1);
         chk("R9", "latch2_n", k, latch2_n, ~l2);
         chk("R9", "dma_a1", k, dma_a1, a1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      idle_chk("R11", 0);
      rst_n = 1'b1;
      tick();
      idle_chk("R11", 1);

      // R3 R4 R5: every combination of bank select inputs and direction.
      for (int v = 0; v < 16; v++)
         cpu_run(v[3], v[2], v[1], v[0]);

      // R2: second strobe fall inside a running cycle is kept.
      addr_hi = 1'b1; addr_b0 = 1'b0; hbe_n = 1'b0; wr_req = 1'b0;
      as_n = 1'b0;
      for (int k = 1; k <= 14; k++) begin
         logic row;
         tick();
         row = (k >= LAUNCH && k <= LAUNCH + CCOL) ||
               (k >= 5 + LAUNCH && k <= 5 + LAUNCH + CCOL);
         chk("R2", "ras_n relaunch", k, ras_n, ~row);
         if (k == 2) as_n = 1'b1;
         if (k == 5) as_n = 1'b0;
      end
      as_n = 1'b1;
      repeat (4) tick();

      // R6 R7 R8 R9 R10: hold arrives with alignment already low.
      align_n = 1'b0;
      hold_ack_n = 1'b0;
      dma_trace(3, 3 + 2 * WLEN + 12);
      hold_ack_n = 1'b1;
      align_n = 1'b1;
      repeat (4) tick();
      idle_chk("R10", 0);

      // R6: alignment high blocks the start, then releases it.
      hold_ack_n = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         tick();
         chk("R6", "dma_oe_n blocked", k, dma_oe_n, 1'b1);
         chk("R6", "ras_n blocked", k, ras_n, 1'b1);
      end
      align_n = 1'b0;
      dma_trace(1, 1 + 2 * WLEN + 6);
      hold_ack_n = 1'b1;
      align_n = 1'b1;
      repeat (4) tick();
      idle_chk("R10", 0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule